// File: doc/BRIEF.md
# Level and Latched Interrupt Controller

This block gathers up to 32 interrupt sources into one interrupt request for a processor. Software reaches it over a plain 32-bit register bus with address, write enable, write data and combinational read data. Most sources are level-sensitive. Each passes through a two-flop synchronizer and shows live in the cause register, so it clears as soon as its source drops. Cause bit 1 is the exception. It latches a press of an active-low reset pushbutton and holds until software writes a 1 to that bit. Cause bit 16 is a read-only view of the live button level. A mask register chooses which causes reach the interrupt output. The block also reports the lowest-numbered pending line, which is the order in which a find-first-set handler services them.

Writing any value to the trigger register starts a fixed-length platform reset pulse. A small state machine times that pulse. Its states are `RP_IDLE` and `RP_PULSE`:
- A write to the trigger register in `RP_IDLE` takes the machine to `RP_PULSE`.
- After the last pulse cycle, `RP_PULSE` returns to `RP_IDLE`.

The button latch is a second state machine with states `BL_CLEAR` and `BL_HELD`:
- A press edge in `BL_CLEAR` takes it to `BL_HELD`.
- An acknowledge write with no new press in the same cycle takes `BL_HELD` back to `BL_CLEAR`.

Top module: `lvl_latch_irq_ctrl`

## Requirements
- R1: After reset the mask register reads 0x00000000. The button cause (bit 1) is clear. `cpu_irq` and `plat_rst` are low. With the button released, the cause register reads 0x00010000.
- R2: A source bit other than 1 and 16 appears at the same position of the cause register (byte offset 0x00) two clocks after it changes, and clears when the source drops. Writing 1 to such a bit has no effect on it.
- R3: The mask register at byte offset 0x04 is read/write. A 1 in a bit enables that line and a 0 disables it.
- R4: The mask never changes the value read from a cause bit. It only decides whether that bit reaches `cpu_irq`.
- R5: A high-to-low transition of the synchronized `btn_n` sets cause bit 1. The bit stays set after release until a write to offset 0x00 with data bit 1 equal to 1. A write with bit 1 equal to 0 leaves it set.
- R6: Cause bit 16 reads the synchronized `btn_n` level: 0 while pressed, 1 while released. It never makes a line pending, whatever the mask holds. Inputs `src_irq[1]` and `src_irq[16]` are ignored.
- R7: Any write to byte offset 0x24 drives `plat_rst` high from the next clock for exactly 16 clocks. A further write while the pulse runs neither extends nor restarts it.
- R8: `cpu_irq` is high exactly when some cause bit and its mask bit are both 1, with bit 16 excluded.
- R9: `pend_valid` equals `cpu_irq`. `pend_idx` gives the lowest-numbered pending line, and 0 when none is pending.
- R10: Writing 0x00000000 to the mask and then 0xFFFFFFFF to the cause leaves `cpu_irq` low and cause bit 1 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write enable, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| src_irq | input | 32 | Asynchronous level interrupt sources |
| btn_n | input | 1 | Asynchronous reset button, low while pressed |
| cpu_irq | output | 1 | Combined interrupt request |
| plat_rst | output | 1 | Platform reset pulse |
| pend_idx | output | 5 | Lowest pending line number |
| pend_valid | output | 1 | Some line is pending |

## Verification
The bench builds the block with its default parameters: 32 lines, two synchronizer stages, button cause at bit 1, button level at bit 16, and a 16-clock reset pulse. With these values, line 31 is reachable as the upper boundary of the lowest-pending search. Bit 16 can be masked on to show that it never pends. The whole pulse is short enough to count cycle by cycle, including a second trigger write that lands mid-pulse.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
    localparam int unsigned OFF_CAUSE = 32'h00;
    localparam int unsigned OFF_MASK  = 32'h04;
    localparam int unsigned OFF_RESET = 32'h24;

    typedef enum logic {
        RP_IDLE,
        RP_PULSE
    } rp_state_t;

    typedef enum logic {
        BL_CLEAR,
        BL_HELD
    } bl_state_t;
endpackage

// File: rtl/lvl_sync.sv
module lvl_sync #(
    parameter int unsigned WIDTH     = 1,
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= {WIDTH{RESET_VAL}};
            else        stg[s] <= (s == 0) ? d : stg[(s == 0) ? 0 : s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/lvl_btn_latch.sv
module lvl_btn_latch
    import lvl_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic btn_lvl,
    input  logic ack,
    output logic latched
);
    bl_state_t state_q, state_d;
    logic      prev_q;
    logic      press;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= btn_lvl;
    end

    assign press = prev_q & ~btn_lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BL_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BL_CLEAR: if (press)        state_d = BL_HELD;
            BL_HELD:  if (ack && !press) state_d = BL_CLEAR;
            default:                    state_d = BL_CLEAR;
        endcase
    end

    assign latched = (state_q == BL_HELD);

    AST_PRESS_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        press |=> latched); // R5
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        latched && !ack |=> latched); // R5
endmodule

// File: rtl/lvl_rst_pulse.sv
module lvl_rst_pulse
    import lvl_irq_pkg::*;
#(
    parameter int unsigned PULSE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    output logic pulse
);
    localparam int unsigned CNT_W = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSE_CYCLES - 1);

    rp_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RP_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == RP_PULSE) cnt_q <= cnt_q + 1'b1;
            else                     cnt_q <= '0;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RP_IDLE:  if (trigger)       state_d = RP_PULSE;
            RP_PULSE: if (cnt_q == LAST) state_d = RP_IDLE;
            default:                     state_d = RP_IDLE;
        endcase
    end

    always_comb begin
        pulse = (state_q == RP_PULSE);
    end

    AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
        trigger && !pulse |=> pulse); // R7
    AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        pulse && cnt_q != LAST |=> pulse); // R7
    AST_PULSE_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pulse) |-> $past(cnt_q) == LAST); // R7
endmodule

// File: rtl/lvl_first_set.sv
module lvl_first_set #(
    parameter int unsigned WIDTH = 32,
    localparam int unsigned IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] vec,
    output logic [IDX_W-1:0] idx,
    output logic             valid
);
    always_comb begin
        idx   = '0;
        valid = 1'b0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx   = IDX_W'(i);
                valid = 1'b1;
            end
        end
    end

    always_comb begin
        if (valid) AST_IDX_SET: assert (vec[idx]); // R9
    end
endmodule

// File: rtl/lvl_latch_irq_ctrl.sv
module lvl_latch_irq_ctrl
    import lvl_irq_pkg::*;
#(
    parameter int unsigned NUM_LINES     = 32,
    parameter int unsigned ADDR_W        = 8,
    parameter int unsigned SYNC_STAGES   = 2,
    parameter int unsigned BTN_CAUSE_BIT = 1,
    parameter int unsigned BTN_LEVEL_BIT = 16,
    parameter int unsigned RST_CYCLES    = 16,
    localparam int unsigned IDX_W        = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_LINES-1:0] src_irq,
    input  logic                 btn_n,
    output logic                 cpu_irq,
    output logic                 plat_rst,
    output logic [IDX_W-1:0]     pend_idx,
    output logic                 pend_valid
);
    localparam logic [NUM_LINES-1:0] SPECIAL =
        (NUM_LINES'(1) << BTN_CAUSE_BIT) | (NUM_LINES'(1) << BTN_LEVEL_BIT);

    logic [NUM_LINES-1:0] src_s;
    logic                 btn_s;
    logic                 btn_held;
    logic [NUM_LINES-1:0] mask_q;
    logic [NUM_LINES-1:0] cause;
    logic [NUM_LINES-1:0] pending;
    logic                 sel_cause, sel_mask, sel_reset;
    logic                 unused_src;

    assign sel_cause = (bus_addr == ADDR_W'(OFF_CAUSE));
    assign sel_mask  = (bus_addr == ADDR_W'(OFF_MASK));
    assign sel_reset = (bus_addr == ADDR_W'(OFF_RESET));

    lvl_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_src_sync (
        .clk(clk), .rst_n(rst_n), .d(src_irq), .q(src_s)
    );

    lvl_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_btn_sync (
        .clk(clk), .rst_n(rst_n), .d(btn_n), .q(btn_s)
    );

    lvl_btn_latch u_btn (
        .clk(clk), .rst_n(rst_n), .btn_lvl(btn_s),
        .ack(bus_we && sel_cause && bus_wdata[BTN_CAUSE_BIT]),
        .latched(btn_held)
    );

    lvl_rst_pulse #(.PULSE_CYCLES(RST_CYCLES)) u_rst (
        .clk(clk), .rst_n(rst_n), .trigger(bus_we && sel_reset), .pulse(plat_rst)
    );

    assign unused_src = ^(src_s & SPECIAL);

    for (genvar b = 0; b < NUM_LINES; b++) begin : g_cause
        if (b == BTN_CAUSE_BIT) begin : g_btn
            assign cause[b]   = btn_held;
            assign pending[b] = btn_held & mask_q[b];
        end else if (b == BTN_LEVEL_BIT) begin : g_lvl
            assign cause[b]   = btn_s;
            assign pending[b] = 1'b0;
        end else begin : g_src
            assign cause[b]   = src_s[b];
            assign pending[b] = src_s[b] & mask_q[b];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  mask_q <= '0;
        else if (bus_we && sel_mask) mask_q <= bus_wdata[NUM_LINES-1:0];
    end

    always_comb begin
        bus_rdata = '0;
        if (sel_cause)     bus_rdata[NUM_LINES-1:0] = cause;
        else if (sel_mask) bus_rdata[NUM_LINES-1:0] = mask_q;
    end

    lvl_first_set #(.WIDTH(NUM_LINES)) u_ffs (
        .vec(pending), .idx(pend_idx), .valid(pend_valid)
    );

    assign cpu_irq = |pending;

    AST_IRQ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq == pend_valid); // R9
    AST_NO_LEVEL_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        !(pend_valid && pend_idx == IDX_W'(BTN_LEVEL_BIT))); // R6
    AST_IDX_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> mask_q[pend_idx]); // R8
    AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && sel_mask |=> mask_q == $past(bus_wdata[NUM_LINES-1:0])); // R3
endmodule

// File: tb/test_lvl_latch_irq_ctrl.sv
module test_lvl_latch_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] src_irq = '0;
    logic        btn_n = 1'b1;
    logic        cpu_irq, plat_rst, pend_valid;
    logic [4:0]  pend_idx;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lvl_latch_irq_ctrl i_lvl_latch_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_irq(src_irq),
        .btn_n(btn_n), .cpu_irq(cpu_irq), .plat_rst(plat_rst),
        .pend_idx(pend_idx), .pend_valid(pend_valid)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 cpu_irq", 32'(cpu_irq), 0);
        chk("R1 plat_rst", 32'(plat_rst), 0);
        rd(8'h04, v); chk("R1 mask", v, 32'h0);
        rd(8'h00, v); chk("R1 cause", v, 32'h0001_0000);
    endtask

    task automatic t_level();
        logic [31:0] v;
        src_irq = 32'h20; wait_cyc(3);
        rd(8'h00, v); chk("R2 cause live", v, 32'h0001_0020);
        chk("R4 masked irq", 32'(cpu_irq), 0);
        wr(8'h04, 32'h20);
        rd(8'h04, v); chk("R3 mask read", v, 32'h20);
        chk("R8 irq on", 32'(cpu_irq), 1);
        chk("R9 idx", {27'b0, pend_idx}, 5);
        wr(8'h00, 32'h20);
        rd(8'h00, v); chk("R2 w1 no effect", v, 32'h0001_0020);
        src_irq = 32'h0; wait_cyc(3);
        rd(8'h00, v); chk("R2 self clear", v, 32'h0001_0000);
        chk("R8 irq off", 32'(cpu_irq), 0);
        chk("R9 valid off", 32'(pend_valid), 0);
    endtask

    task automatic t_order();
        logic [31:0] v;
        wr(8'h04, 32'hFFFF_FFFF);
        src_irq = 32'h8010_0080; wait_cyc(3);
        chk("R9 lowest 7", {27'b0, pend_idx}, 7);
        src_irq = 32'h8010_0000; wait_cyc(3);
        chk("R9 lowest 20", {27'b0, pend_idx}, 20);
        src_irq = 32'h8000_0000; wait_cyc(3);
        chk("R9 top 31", {27'b0, pend_idx}, 31);
        wr(8'h04, 32'h7FFF_FFFF);
        rd(8'h00, v); chk("R4 cause kept", v, 32'h8001_0000);
        chk("R3 mask off", 32'(cpu_irq), 0);
        src_irq = 32'h0001_0002; wr(8'h04, 32'hFFFF_FFFF); wait_cyc(3);
        chk("R6 src 1/16 ignored", 32'(cpu_irq), 0);
        src_irq = '0; wait_cyc(3);
    endtask

    task automatic t_button();
        logic [31:0] v;
        wr(8'h04, 32'h0001_0000);
        btn_n = 1'b0; wait_cyc(4);
        rd(8'h00, v); chk("R6 level pressed + R5 latch", v, 32'h0000_0002);
        chk("R6 bit16 never pends", 32'(cpu_irq), 0);
        wr(8'h04, 32'h0000_0002);
        chk("R5 irq", 32'(cpu_irq), 1);
        chk("R9 idx 1", {27'b0, pend_idx}, 1);
        btn_n = 1'b1; wait_cyc(4);
        rd(8'h00, v); chk("R5 sticky", v, 32'h0001_0002);
        wr(8'h00, 32'hFFFF_FFFD);
        rd(8'h00, v); chk("R5 write0 keeps", v, 32'h0001_0002);
        wr(8'h00, 32'h0000_0002);
        rd(8'h00, v); chk("R5 ack clears", v, 32'h0001_0000);
        chk("R8 after ack", 32'(cpu_irq), 0);
    endtask

    task automatic t_quiesce();
        logic [31:0] v;
        wr(8'h04, 32'hFFFF_FFFF);
        src_irq = 32'h0000_0100; btn_n = 1'b0; wait_cyc(4);
        btn_n = 1'b1; src_irq = '0; wait_cyc(4);
        chk("R10 pre", 32'(cpu_irq), 1);
        wr(8'h04, 32'h0);
        wr(8'h00, 32'hFFFF_FFFF);
        chk("R10 irq", 32'(cpu_irq), 0);
        rd(8'h00, v); chk("R10 cause", v, 32'h0001_0000);
    endtask

    task automatic t_pulse();
        int highs = 0;
        wr(8'h24, 32'h0);
        chk("R7 start", 32'(plat_rst), 1);
        highs++;
        wr(8'h24, 32'h5A);
        if (plat_rst) highs++;
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            if (plat_rst) highs++;
        end
        chk("R7 length", 32'(highs), 16);
        chk("R7 end", 32'(plat_rst), 0);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        t_reset();
        t_level();
        t_order();
        t_button();
        t_quiesce();
        t_pulse();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule